// File: doc/BRIEF.md
# Integer Multiply-Divide Unit

This unit computes integer products, quotients and remainders for a 64-bit datapath. A request carries an operation code and two 64-bit operands. It is accepted on a clock edge where `start_i` and `ready_o` are both high. Some time later the unit raises `done_o` for one cycle, and `result_o` then holds the 64-bit answer.

Multiplies go through a single-cycle product path, so each one takes a fixed two cycles. Divides and remainders use an iterative radix-2 restoring loop on operand magnitudes. A 32-bit form takes 32 iterations and a 64-bit form takes 64. Signs are fixed up at the end so that division truncates toward zero. A zero divisor never traps, and neither does the most-negative dividend divided by -1: in both cases the unit silently uses a divisor of 1.

Every 32-bit form sign-extends its 32-bit answer to 64 bits, including the unsigned divide and remainder forms. The operation code is 7 bits wide and carries the codes a neighbouring decoder produces.

Top module: `muldiv_unit`

## Requirements
- R1: `ready_o` is high exactly when the unit is idle. A `start_i` pulse raised while `ready_o` is low is ignored and does not change the result of the operation already running.
- R2: `done_o` is high for a single cycle per operation, and `result_o` keeps its value in every cycle where `done_o` is low. After reset, `result_o` is 0, `done_o` is 0 and `ready_o` is 1.
- R3: Code 0x38 returns the low 32 bits of the product of the two low operand words, sign-extended to 64 bits. The upper operand words are ignored.
- R4: Code 0x39 (signed) and code 0x3A (unsigned) return bits 63:32 of the 64-bit product of the low operand words, sign-extended to 64 bits.
- R5: Code 0x3B returns the low 64 bits of the full product. Code 0x3C (signed) and code 0x3D (unsigned) return bits 127:64 of the 128-bit product.
- R6: Code 0x3E sign-extends the two low words and returns the 64-bit product. Code 0x3F does the same after zero-extending them.
- R7: Signed 64-bit quotient (code 0x44) and remainder (code 0x45) truncate toward zero, and the remainder carries the sign of the dividend.
- R8: Unsigned 64-bit quotient (code 0x46) and remainder (code 0x47) treat both operands as unsigned.
- R9: The 32-bit divide codes use only the low operand words: 0x40 for signed quotient, 0x41 for signed remainder, 0x42 for unsigned quotient and 0x43 for unsigned remainder. The 32-bit answer is sign-extended to 64 bits even for the unsigned codes.
- R10: A divisor of zero is replaced by 1, so the quotient equals the dividend (the extended low word for the 32-bit codes) and the remainder is 0.
- R11: For a signed divide with the most-negative dividend of the selected width and a divisor of -1, the divisor is replaced by 1. The quotient is then that most-negative value and the remainder is 0.
- R12: A multiply raises `done_o` two clock edges after the accepting edge. A divide or remainder raises `done_o` no later than 66 edges after the accepting edge.
- R13: Any code outside 0x38 to 0x47 completes like a multiply, with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request valid |
| op_i | input | 7 | Operation code |
| opa_i | input | 64 | First operand (multiplicand or dividend) |
| opb_i | input | 64 | Second operand (multiplier or divisor) |
| ready_o | output | 1 | Unit idle; a request is accepted this cycle if `start_i` is high |
| done_o | output | 1 | One-cycle pulse: `result_o` has been updated |
| result_o | output | 64 | Result, held until the next completion |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath and a 32-bit half word. With these widths the 128-bit high products can be checked, and so can both most-negative/-1 cases (2^63 and 2^31) and the sign extension of the unsigned 32-bit quotients. The default widths also fix the iteration counts at 32 and 64, so the bench can check the latency bound against the full-length divide. A directed corner test is followed by a pseudo-random sweep over all sixteen codes, checked against a behavioural model.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int XLEN = 64;
    localparam int HALF = 32;
    localparam int OPW  = 7;

    localparam logic [OPW-1:0] OP_MUL32     = 7'h38;
    localparam logic [OPW-1:0] OP_MULHI32S  = 7'h39;
    localparam logic [OPW-1:0] OP_MULHI32U  = 7'h3A;
    localparam logic [OPW-1:0] OP_MUL64     = 7'h3B;
    localparam logic [OPW-1:0] OP_MULHI64S  = 7'h3C;
    localparam logic [OPW-1:0] OP_MULHI64U  = 7'h3D;
    localparam logic [OPW-1:0] OP_WMULS     = 7'h3E;
    localparam logic [OPW-1:0] OP_WMULU     = 7'h3F;
    localparam logic [OPW-1:0] OP_DIV32S    = 7'h40;
    localparam logic [OPW-1:0] OP_REM32S    = 7'h41;
    localparam logic [OPW-1:0] OP_DIV32U    = 7'h42;
    localparam logic [OPW-1:0] OP_REM32U    = 7'h43;
    localparam logic [OPW-1:0] OP_DIV64S    = 7'h44;
    localparam logic [OPW-1:0] OP_REM64S    = 7'h45;
    localparam logic [OPW-1:0] OP_DIV64U    = 7'h46;
    localparam logic [OPW-1:0] OP_REM64U    = 7'h47;

    // Which slice of the product a multiply returns
    typedef enum logic [2:0] {
        MS_ZERO,
        MS_LO_HALF,
        MS_HI_HALF,
        MS_LO_FULL,
        MS_HI_FULL
    } msel_e;

    typedef struct packed {
        logic  is_div;
        logic  is_rem;
        logic  sgn;
        logic  half;
        msel_e msel;
    } ctrl_t;

    localparam ctrl_t CTRL_NONE = '{is_div: 1'b0, is_rem: 1'b0, sgn: 1'b0,
                                    half: 1'b0, msel: MS_ZERO};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV
    } state_e;

    function automatic ctrl_t decode_op(input logic [OPW-1:0] op);
        ctrl_t c;
        c = CTRL_NONE;
        case (op)
            OP_MUL32:    begin c.half = 1'b1; c.sgn = 1'b1; c.msel = MS_LO_HALF; end
            OP_MULHI32S: begin c.half = 1'b1; c.sgn = 1'b1; c.msel = MS_HI_HALF; end
            OP_MULHI32U: begin c.half = 1'b1;               c.msel = MS_HI_HALF; end
            OP_MUL64:    begin                c.sgn = 1'b1; c.msel = MS_LO_FULL; end
            OP_MULHI64S: begin                c.sgn = 1'b1; c.msel = MS_HI_FULL; end
            OP_MULHI64U: begin                              c.msel = MS_HI_FULL; end
            OP_WMULS:    begin c.half = 1'b1; c.sgn = 1'b1; c.msel = MS_LO_FULL; end
            OP_WMULU:    begin c.half = 1'b1;               c.msel = MS_LO_FULL; end
            OP_DIV32S:   begin c.is_div = 1'b1; c.half = 1'b1; c.sgn = 1'b1; end
            OP_REM32S:   begin c.is_div = 1'b1; c.half = 1'b1; c.sgn = 1'b1; c.is_rem = 1'b1; end
            OP_DIV32U:   begin c.is_div = 1'b1; c.half = 1'b1; end
            OP_REM32U:   begin c.is_div = 1'b1; c.half = 1'b1; c.is_rem = 1'b1; end
            OP_DIV64S:   begin c.is_div = 1'b1; c.sgn = 1'b1; end
            OP_REM64S:   begin c.is_div = 1'b1; c.sgn = 1'b1; c.is_rem = 1'b1; end
            OP_DIV64U:   begin c.is_div = 1'b1; end
            OP_REM64U:   begin c.is_div = 1'b1; c.is_rem = 1'b1; end
            default:     c = CTRL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mdu_prep.sv
// Decodes the request and turns divide operands into unsigned magnitudes
module mdu_prep
    import mdu_pkg::*;
#(
    parameter int XLEN_P = mdu_pkg::XLEN,
    parameter int HALF_P = mdu_pkg::HALF
) (
    input  logic [OPW-1:0]    op_i,
    input  logic [XLEN_P-1:0] a_i,
    input  logic [XLEN_P-1:0] b_i,
    output ctrl_t             ctrl_o,
    output logic [XLEN_P-1:0] dvd_mag_o,
    output logic [XLEN_P-1:0] dvs_mag_o,
    output logic              neg_quo_o,
    output logic              neg_rem_o
);
    localparam int EXT = XLEN_P - HALF_P;

    ctrl_t             ctrl;
    logic [XLEN_P-1:0] ea, eb, db, min_v;
    logic              ovf, a_neg, b_neg;

    always_comb begin
        ctrl = decode_op(op_i);
        if (ctrl.half) begin
            ea    = {{EXT{ctrl.sgn & a_i[HALF_P-1]}}, a_i[HALF_P-1:0]};
            eb    = {{EXT{ctrl.sgn & b_i[HALF_P-1]}}, b_i[HALF_P-1:0]};
            min_v = {{(EXT+1){1'b1}}, {(HALF_P-1){1'b0}}};
        end else begin
            ea    = a_i;
            eb    = b_i;
            min_v = {1'b1, {(XLEN_P-1){1'b0}}};
        end
        // quotient overflow case: most-negative value over -1
        ovf   = ctrl.sgn && (ea == min_v) && (eb == '1);
        db    = ((eb == '0) || ovf) ? XLEN_P'(1) : eb;
        a_neg = ctrl.sgn & ea[XLEN_P-1];
        b_neg = ctrl.sgn & db[XLEN_P-1];
    end

    assign ctrl_o    = ctrl;
    assign dvd_mag_o = a_neg ? (~ea + XLEN_P'(1)) : ea;
    assign dvs_mag_o = b_neg ? (~db + XLEN_P'(1)) : db;
    assign neg_quo_o = a_neg ^ b_neg;
    assign neg_rem_o = a_neg;

endmodule

// File: rtl/mdu_mul.sv
// Single-cycle product path with slice selection
module mdu_mul
    import mdu_pkg::*;
#(
    parameter int XLEN_P = mdu_pkg::XLEN,
    parameter int HALF_P = mdu_pkg::HALF
) (
    input  logic [XLEN_P-1:0] a_i,
    input  logic [XLEN_P-1:0] b_i,
    input  logic              sgn_i,
    input  logic              half_i,
    input  msel_e             msel_i,
    output logic [XLEN_P-1:0] res_o
);
    localparam int EXT = XLEN_P - HALF_P;
    localparam int PW  = 2 * XLEN_P;

    logic [XLEN_P:0]   xa, xb;
    logic [PW-1:0]     prod;
    logic [HALF_P-1:0] lo_h, hi_h;

    always_comb begin
        if (half_i) begin
            xa = {{(EXT+1){sgn_i & a_i[HALF_P-1]}}, a_i[HALF_P-1:0]};
            xb = {{(EXT+1){sgn_i & b_i[HALF_P-1]}}, b_i[HALF_P-1:0]};
        end else begin
            xa = {sgn_i & a_i[XLEN_P-1], a_i};
            xb = {sgn_i & b_i[XLEN_P-1], b_i};
        end
        prod = PW'($signed(xa) * $signed(xb));
        lo_h = prod[HALF_P-1:0];
        hi_h = prod[2*HALF_P-1:HALF_P];
        case (msel_i)
            MS_LO_HALF: res_o = {{EXT{lo_h[HALF_P-1]}}, lo_h};
            MS_HI_HALF: res_o = {{EXT{hi_h[HALF_P-1]}}, hi_h};
            MS_LO_FULL: res_o = prod[XLEN_P-1:0];
            MS_HI_FULL: res_o = prod[PW-1:XLEN_P];
            default:    res_o = '0;
        endcase
    end

endmodule

// File: rtl/mdu_div.sv
// Radix-2 restoring divider on unsigned magnitudes
module mdu_div #(
    parameter int XLEN_P = mdu_pkg::XLEN,
    parameter int HALF_P = mdu_pkg::HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              half_i,
    input  logic [XLEN_P-1:0] dvd_i,
    input  logic [XLEN_P-1:0] dvs_i,
    output logic [XLEN_P-1:0] quo_o,
    output logic [XLEN_P-1:0] rem_o,
    output logic              fin_o
);
    localparam int CW = $clog2(XLEN_P + 1);

    logic [XLEN_P-1:0] quo_q, rem_q, dvs_q;
    logic [CW-1:0]     cnt_q;
    logic              busy_q, fin_q;
    logic [XLEN_P:0]   trial;

    assign trial = {rem_q, quo_q[XLEN_P-1]} - {1'b0, dvs_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                dvs_q  <= dvs_i;
                rem_q  <= '0;
                // a half-width dividend starts in the upper half so that
                // HALF_P iterations are enough
                quo_q  <= half_i ? {dvd_i[HALF_P-1:0], {(XLEN_P-HALF_P){1'b0}}} : dvd_i;
                cnt_q  <= half_i ? CW'(HALF_P) : CW'(XLEN_P);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!trial[XLEN_P]) begin
                    rem_q <= trial[XLEN_P-1:0];
                    quo_q <= {quo_q[XLEN_P-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[XLEN_P-2:0], quo_q[XLEN_P-1]};
                    quo_q <= {quo_q[XLEN_P-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;
    assign fin_o = fin_q;

    // R12: the controller only loads a new divide while the loop is idle
    a_r12_load_when_idle: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !busy_q);

    // R10: substitution leaves no zero divisor for the loop
    a_r10_divisor_nonzero: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (dvs_i != '0));

    // R7: a finished division leaves a remainder below the divisor
    a_r7_remainder_bound: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> (rem_q < dvs_q));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import mdu_pkg::*;
#(
    parameter int XLEN_P = mdu_pkg::XLEN,
    parameter int HALF_P = mdu_pkg::HALF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [OPW-1:0]    op_i,
    input  logic [XLEN_P-1:0] opa_i,
    input  logic [XLEN_P-1:0] opb_i,
    output logic              ready_o,
    output logic              done_o,
    output logic [XLEN_P-1:0] result_o
);
    localparam int EXT = XLEN_P - HALF_P;

    state_e            state_q;
    ctrl_t             ctrl, ctrl_q;
    logic [XLEN_P-1:0] a_q, b_q, result_q;
    logic              done_q, neg_quo_q, neg_rem_q;
    logic [XLEN_P-1:0] dvd_mag, dvs_mag, mul_res;
    logic              neg_quo, neg_rem;
    logic [XLEN_P-1:0] div_quo, div_rem;
    logic              div_fin, accept;
    logic [XLEN_P-1:0] quo_s, rem_s, pick, div_res;

    assign ready_o = (state_q == ST_IDLE);
    assign accept  = start_i && ready_o;

    mdu_prep #(.XLEN_P(XLEN_P), .HALF_P(HALF_P)) u_prep (
        .op_i      (op_i),
        .a_i       (opa_i),
        .b_i       (opb_i),
        .ctrl_o    (ctrl),
        .dvd_mag_o (dvd_mag),
        .dvs_mag_o (dvs_mag),
        .neg_quo_o (neg_quo),
        .neg_rem_o (neg_rem)
    );

    mdu_mul #(.XLEN_P(XLEN_P), .HALF_P(HALF_P)) u_mul (
        .a_i    (a_q),
        .b_i    (b_q),
        .sgn_i  (ctrl_q.sgn),
        .half_i (ctrl_q.half),
        .msel_i (ctrl_q.msel),
        .res_o  (mul_res)
    );

    mdu_div #(.XLEN_P(XLEN_P), .HALF_P(HALF_P)) u_div (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept && ctrl.is_div),
        .half_i (ctrl.half),
        .dvd_i  (dvd_mag),
        .dvs_i  (dvs_mag),
        .quo_o  (div_quo),
        .rem_o  (div_rem),
        .fin_o  (div_fin)
    );

    // Sign fix-up and width extension of the divider output
    always_comb begin
        quo_s   = neg_quo_q ? (~div_quo + XLEN_P'(1)) : div_quo;
        rem_s   = neg_rem_q ? (~div_rem + XLEN_P'(1)) : div_rem;
        pick    = ctrl_q.is_rem ? rem_s : quo_s;
        div_res = ctrl_q.half ? {{EXT{pick[HALF_P-1]}}, pick[HALF_P-1:0]} : pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctrl_q    <= CTRL_NONE;
            a_q       <= '0;
            b_q       <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            result_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        a_q       <= opa_i;
                        b_q       <= opb_i;
                        ctrl_q    <= ctrl;
                        neg_quo_q <= neg_quo;
                        neg_rem_q <= neg_rem;
                        state_q   <= ctrl.is_div ? ST_DIV : ST_MUL;
                    end
                end
                ST_MUL: begin
                    result_q <= mul_res;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                ST_DIV: begin
                    if (div_fin) begin
                        result_q <= div_res;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;

    // R2: completion is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2: the result only moves on a completion
    a_r2_result_held: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  op = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        ready, done;
    logic [63:0] result;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    muldiv_unit u0 (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op),
        .opa_i(opa), .opb_i(opb), .ready_o(ready), .done_o(done), .result_o(result)
    );

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    // Behavioural model written from the requirements
    function automatic logic [63:0] model(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b);
        longint            sa, sb, sq;
        longint unsigned   ua, ub, uq;
        logic signed [127:0] sp;
        logic [127:0]      up;
        int                ia, ib, iq;
        int unsigned       wa, wb, wq;
        sa = longint'($signed(a[31:0]));
        sb = longint'($signed(b[31:0]));
        ua = {32'b0, a[31:0]};
        ub = {32'b0, b[31:0]};
        case (c)
            7'h38: begin uq = a * b; return sx(uq[31:0]); end
            7'h39: begin sq = sa * sb; return sx(sq[63:32]); end
            7'h3A: begin uq = ua * ub; return sx(uq[63:32]); end
            7'h3B: return a * b;
            7'h3C: begin sp = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b}); return sp[127:64]; end
            7'h3D: begin up = {64'b0, a} * {64'b0, b}; return up[127:64]; end
            7'h3E: begin sq = sa * sb; return sq; end
            7'h3F: return ua * ub;
            7'h40, 7'h41: begin
                ia = a[31:0]; ib = b[31:0];
                if (ib == 0 || (ia == int'(32'h8000_0000) && ib == -1)) ib = 1;
                iq = (c == 7'h41) ? (ia % ib) : (ia / ib);
                return sx(iq);
            end
            7'h42, 7'h43: begin
                wa = a[31:0]; wb = b[31:0];
                if (wb == 0) wb = 1;
                wq = (c == 7'h43) ? (wa % wb) : (wa / wb);
                return sx(wq);
            end
            7'h44, 7'h45: begin
                sa = a; sb = b;
                if (sb == 0 || (sa == 64'h8000_0000_0000_0000 && sb == -1)) sb = 1;
                sq = (c == 7'h45) ? (sa % sb) : (sa / sb);
                return sq;
            end
            7'h46, 7'h47: begin
                ua = a; ub = b;
                if (ub == 0) ub = 1;
                return (c == 7'h47) ? (ua % ub) : (ua / ub);
            end
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] res, output int cyc);
        @(negedge clk);
        while (!ready) @(negedge clk);
        start = 1'b1; op = c; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        res = result;
    endtask

    task automatic do_check(input string tag, input logic [6:0] c, input logic [63:0] a,
                            input logic [63:0] b, input logic [63:0] exp);
        logic [63:0] r;
        int          cyc;
        run_op(c, a, b, r, cyc);
        check(tag, r, exp);
    endtask

    task automatic t_reset();
        check("R2 reset result", result, 64'h0);
        check("R2 reset done", {63'b0, done}, 64'h0);
        check("R1 reset ready", {63'b0, ready}, 64'h1);
    endtask

    task automatic t_mul32();
        do_check("R3 low word product", 7'h38, 64'hDEAD_0000_7FFF_FFFF, 64'hBEEF_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFFE);
        do_check("R4 signed high word", 7'h39, 64'h0000_0000_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, 64'h0);
        do_check("R4 unsigned high word", 7'h3A, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE);
    endtask

    task automatic t_mul64();
        do_check("R5 low full product", 7'h3B, 64'h8000_0000_0000_0000, 64'h2, 64'h0);
        do_check("R5 signed high full", 7'h3C, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        do_check("R5 unsigned high full", 7'h3D, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE);
    endtask

    task automatic t_widen();
        do_check("R6 widening signed", 7'h3E, 64'h1111_1111_8000_0000, 64'h2222_2222_8000_0000, 64'h4000_0000_0000_0000);
        do_check("R6 widening unsigned", 7'h3F, 64'h1111_1111_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFE_0000_0001);
    endtask

    task automatic t_div_signed();
        do_check("R7 signed quotient truncates", 7'h44, -64'sd7, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD);
        do_check("R7 remainder sign of dividend", 7'h45, -64'sd7, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        do_check("R7 positive dividend negative divisor", 7'h45, 64'd7, -64'sd2, 64'd1);
    endtask

    task automatic t_div_unsigned();
        do_check("R8 unsigned quotient", 7'h46, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h7FFF_FFFF_FFFF_FFFF);
        do_check("R8 unsigned remainder", 7'h47, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1);
    endtask

    task automatic t_div32();
        do_check("R9 signed word quotient", 7'h40, 64'hABCD_0000_FFFF_FF9C, 64'h0000_0001_0000_0007, 64'hFFFF_FFFF_FFFF_FFF2);
        do_check("R9 signed word remainder", 7'h41, 64'hABCD_0000_FFFF_FF9C, 64'h0000_0001_0000_0007, 64'hFFFF_FFFF_FFFF_FFFE);
        do_check("R9 unsigned word quotient sign-extended", 7'h42, 64'h0000_0000_FFFF_FFFF, 64'h1234_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
        do_check("R9 unsigned word quotient upper ignored", 7'h42, 64'h1234_5678_FFFF_FFFE, 64'hFFFF_FFFF_0000_0002, 64'h0000_0000_7FFF_FFFF);
        do_check("R9 unsigned word remainder", 7'h43, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0010, 64'hF);
    endtask

    task automatic t_divzero();
        do_check("R10 signed divide by zero", 7'h44, 64'd12345, 64'd0, 64'd12345);
        do_check("R10 signed remainder by zero", 7'h45, 64'd12345, 64'd0, 64'd0);
        do_check("R10 unsigned word divide by zero", 7'h42, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_8000_0000);
        do_check("R10 unsigned remainder by zero", 7'h47, 64'hFFFF_0000_0000_0001, 64'd0, 64'd0);
    endtask

    task automatic t_overflow();
        do_check("R11 full min over -1 quotient", 7'h44, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
        do_check("R11 full min over -1 remainder", 7'h45, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        do_check("R11 word min over -1 quotient", 7'h40, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_8000_0000);
        do_check("R11 word min over -1 remainder", 7'h41, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'h0);
    endtask

    task automatic t_latency();
        logic [63:0] r;
        int          cyc;
        run_op(7'h3B, 64'd3, 64'd5, r, cyc);
        check("R12 multiply latency", 64'(cyc), 64'd2);
        run_op(7'h46, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, r, cyc);
        check("R12 full divide within bound", 64'(cyc <= 66), 64'd1);
        check("R8 full divide value", r, 64'h5555_5555_5555_5555);
        run_op(7'h42, 64'd100, 64'd3, r, cyc);
        check("R12 word divide within bound", 64'(cyc <= 66), 64'd1);
    endtask

    task automatic t_unknown();
        logic [63:0] r;
        int          cyc;
        run_op(7'h37, 64'd9, 64'd9, r, cyc);
        check("R13 unlisted code result", r, 64'h0);
        check("R13 unlisted code latency", 64'(cyc), 64'd2);
        run_op(7'h00, 64'hFFFF, 64'hFFFF, r, cyc);
        check("R13 code zero result", r, 64'h0);
    endtask

    task automatic t_busy_ignored();
        int cyc;
        int n_done;
        @(negedge clk);
        while (!ready) @(negedge clk);
        start = 1'b1; op = 7'h44; opa = 64'd100; opb = 64'd7;
        @(negedge clk);
        check("R1 ready low while busy", {63'b0, ready}, 64'h0);
        op = 7'h3B; opa = 64'd5; opb = 64'd5;
        repeat (3) @(negedge clk);
        start = 1'b0;
        cyc = 4;
        n_done = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check("R1 busy start ignored", result, 64'd14);
        check("R1 ready after completion", {63'b0, ready}, 64'h1);
        repeat (3) begin
            @(negedge clk);
            if (done) n_done++;
        end
        check("R2 single done pulse", 64'(n_done), 64'd0);
        check("R2 result held after done", result, 64'd14);
    endtask

    task automatic t_sweep();
        logic [63:0] lf = 64'hACE1_2345_6789_BDF1;
        for (int i = 0; i < 4; i++) begin
            for (int c = 8'h38; c <= 8'h47; c++) begin
                logic [63:0] a, b, r;
                int          cyc;
                lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                a  = lf;
                lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                b  = (i == 3) ? {56'b0, lf[7:0]} : {lf[31:0], lf[63:32]};
                run_op(7'(c), a, b, r, cyc);
                if (c < 8'h40) check("R5 sweep multiply vs model", r, model(7'(c), a, b));
                else           check("R7 sweep divide vs model", r, model(7'(c), a, b));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mul32();
        t_mul64();
        t_widen();
        t_div_signed();
        t_div_unsigned();
        t_div32();
        t_divzero();
        t_overflow();
        t_latency();
        t_unknown();
        t_busy_ignored();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule